// File: doc/BRIEF.md
# NAND read prefetch FIFO engine

This block pulls a programmed number of bytes from a byte-wide NAND data port into a local 64-byte FIFO without software stepping each byte. The host sets a chip select, a FIFO threshold, a direction and an enable in one configuration register, and the transfer length in a second. It then writes 1 to a control register. From then on the engine strobes the NAND port whenever the device is ready and the FIFO has room. The host polls a status register that packs the bytes still to fetch with the current FIFO fill. For every status read it drains fill/4 whole 32-bit words through a dedicated pop port, with the bytes packed little-endian.

The control register reads back a busy flag. The flag clears by itself once every byte has been fetched and the FIFO is empty. Writing 0 to the control register aborts a transfer and discards everything buffered. Configuration writes are refused while a transfer runs, and a threshold above the FIFO depth is refused at any time. A threshold-reached output tells the host when enough data is waiting. When the length is not a multiple of four, the last word can be popped as a partial word padded with zeros.

Top module: `nand_pf_engine`

## Requirements
- R1: After reset, all four registers read 0, `nand_re` is low and `thr_hit` is low.
- R2: A write to config1 (address 0) stores the chip select from bits 31:24, the threshold from bits 14:8, the enable from bit 7 and the direction from bit 0 (0 = read). Reads return these fields in the same positions and 0 elsewhere, and `nand_cs` drives the stored chip select. The whole write is ignored if its threshold field exceeds 64.
- R3: While busy, writes to config1 and to config2 (address 1, byte count in bits 13:0) are ignored.
- R4: Writing a value with bit 0 = 1 to control (address 2) starts a transfer only when the engine is idle, enable = 1, direction = 0 and the count is nonzero. Control bit 0 reads 1 while a transfer is busy.
- R5: `nand_re` is high only while busy, with bytes still to fetch, a FIFO that is not full and `nand_ready` high. Each strobe captures `nand_dq` at that clock edge as the next byte and lowers the remaining count by one.
- R6: The FIFO holds at most 64 bytes. When it is full, fetching stalls until the host pops.
- R7: A `word_pop` with fill ≥ 4 returns the four oldest bytes on `word_data`, the oldest in bits 7:0, and lowers the fill by 4. When fill < 4, a pop is ignored while bytes remain to fetch. Once the remaining count is 0, such a pop returns the leftover bytes with zero upper lanes and empties the FIFO.
- R8: Status (address 3) reads the remaining count in bits 13:0 and the FIFO fill in bits 30:24. All other bits read 0.
- R9: Once busy with remaining count 0 and an empty FIFO, busy clears on the next clock edge.
- R10: Writing a value with bit 0 = 0 to control clears busy, the remaining count and the FIFO on that edge.
- R11: `thr_hit` is high while busy with a nonempty FIFO whose fill is at least the threshold, or whose remaining count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 config1, 1 config2, 2 control, 3 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| word_pop | input | 1 | Pop one 32-bit word from the FIFO |
| word_data | output | 32 | Word at the FIFO head, little-endian |
| thr_hit | output | 1 | Threshold reached or final bytes waiting |
| nand_cs | output | 8 | Configured chip select |
| nand_re | output | 1 | Read strobe to the NAND data port |
| nand_ready | input | 1 | NAND device ready |
| nand_dq | input | 8 | NAND data byte |

## Verification
A wrong FIFO pointer or a lost push shows up on the next popped word as a byte out of sequence, or as one repeated or shifted, because the bench feeds a position-dependent byte pattern. A drifting fill or remaining counter shows up on the very next status read. It also shows later as a busy flag that never clears or clears too early. Gating faults on the strobe show up as a full-FIFO status with a nonzero strobe, or as a remaining count that stops matching the strobes.

// File: rtl/nand_pf_pkg.sv
package nand_pf_pkg;

  typedef enum logic [1:0] {
    RA_CFG1 = 2'd0,
    RA_CFG2 = 2'd1,
    RA_CTRL = 2'd2,
    RA_STAT = 2'd3
  } pf_reg_e;

  localparam int unsigned REG_W     = 32;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned LANES     = REG_W / BYTE_W;
  localparam int unsigned CS_LSB    = 24;
  localparam int unsigned THR_LSB   = 8;
  localparam int unsigned THR_W     = 7;
  localparam int unsigned EN_BIT    = 7;
  localparam int unsigned DIR_BIT   = 0;
  localparam int unsigned CNT_LSB   = 0;
  localparam int unsigned FILL_LSB  = 24;
  localparam int unsigned RUN_BIT   = 0;

endpackage

// File: rtl/nand_pf_regs.sv
module nand_pf_regs
  import nand_pf_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int CS_W    = 8,
  parameter int FILL_W  = 7,
  parameter int THR_MAX = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              busy,
  input  logic [CNT_W-1:0]  remaining,
  input  logic [FILL_W-1:0] fill,
  output logic [CS_W-1:0]   cfg_cs,
  output logic [THR_W-1:0]  cfg_thr,
  output logic [CNT_W-1:0]  cfg_cnt,
  output logic              start_req,
  output logic              stop_req,
  output logic [REG_W-1:0]  reg_rdata
);

  pf_reg_e          addr_e;
  logic [THR_W-1:0] thr_in;
  logic             wr_cfg1;
  logic             wr_cfg2;
  logic             wr_ctrl;
  logic             cfg_en;
  logic             cfg_dir;
  logic [CS_W-1:0]  cs_d;
  logic [THR_W-1:0] thr_d;
  logic             en_d;
  logic             dir_d;
  logic [CNT_W-1:0] cnt_d;
  logic             unused_wbits;

  assign addr_e       = pf_reg_e'(reg_addr);
  assign thr_in       = reg_wdata[THR_LSB +: THR_W];
  assign unused_wbits = ^reg_wdata;

  // configuration is frozen while a transfer is running
  assign wr_cfg1 = reg_wr && (addr_e == RA_CFG1) && !busy &&
                   (thr_in <= THR_W'(THR_MAX));
  assign wr_cfg2 = reg_wr && (addr_e == RA_CFG2) && !busy;
  assign wr_ctrl = reg_wr && (addr_e == RA_CTRL);

  assign start_req = wr_ctrl && reg_wdata[RUN_BIT] && !busy &&
                     cfg_en && !cfg_dir && (cfg_cnt != '0);
  assign stop_req  = wr_ctrl && !reg_wdata[RUN_BIT];

  always_comb begin
    cs_d  = reg_wdata[CS_LSB +: CS_W];
    thr_d = thr_in;
    en_d  = reg_wdata[EN_BIT];
    dir_d = reg_wdata[DIR_BIT];
    cnt_d = reg_wdata[CNT_LSB +: CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_cs  <= '0;
      cfg_thr <= '0;
      cfg_en  <= 1'b0;
      cfg_dir <= 1'b0;
    end else if (wr_cfg1) begin
      cfg_cs  <= cs_d;
      cfg_thr <= thr_d;
      cfg_en  <= en_d;
      cfg_dir <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_cnt <= '0;
    end else if (wr_cfg2) begin
      cfg_cnt <= cnt_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (addr_e)
      RA_CFG1: begin
        reg_rdata[CS_LSB +: CS_W]   = cfg_cs;
        reg_rdata[THR_LSB +: THR_W] = cfg_thr;
        reg_rdata[EN_BIT]           = cfg_en;
        reg_rdata[DIR_BIT]          = cfg_dir;
      end
      RA_CFG2: reg_rdata[CNT_LSB +: CNT_W] = cfg_cnt;
      RA_CTRL: reg_rdata[RUN_BIT] = busy;
      RA_STAT: begin
        reg_rdata[CNT_LSB +: CNT_W]   = remaining;
        reg_rdata[FILL_LSB +: FILL_W] = fill;
      end
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/nand_pf_fetch.sv
module nand_pf_fetch #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic [CNT_W-1:0] cfg_cnt,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  input  logic             nand_ready,
  output logic             busy,
  output logic [CNT_W-1:0] remaining,
  output logic             nand_re
);

  logic             busy_d;
  logic [CNT_W-1:0] rem_d;
  logic             busy_en;
  logic             rem_en;

  assign nand_re = busy && (remaining != '0) && !fifo_full && nand_ready;

  always_comb begin
    busy_d = busy;
    rem_d  = remaining;
    if (stop_req) begin
      busy_d = 1'b0;
      rem_d  = '0;
    end else if (start_req) begin
      busy_d = 1'b1;
      rem_d  = cfg_cnt;
    end else begin
      if (nand_re) begin
        rem_d = remaining - CNT_W'(1);
      end
      if (busy && (remaining == '0) && fifo_empty) begin
        busy_d = 1'b0;
      end
    end
  end

  assign busy_en = busy_d != busy;
  assign rem_en  = stop_req || start_req || nand_re;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else if (busy_en) begin
      busy <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
    end else if (rem_en) begin
      remaining <= rem_d;
    end
  end

endmodule

// File: rtl/nand_pf_fifo.sv
module nand_pf_fifo #(
  parameter int DEPTH  = 64,
  parameter int FILL_W = 7,
  parameter int BYTE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    push,
  input  logic [BYTE_W-1:0]       push_data,
  input  logic                    pop_req,
  input  logic                    tail_ok,
  output logic [LANES*BYTE_W-1:0] word,
  output logic [FILL_W-1:0]       fill,
  output logic                    full,
  output logic                    empty
);

  localparam int PTR_W = $clog2(DEPTH);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;
  logic [PTR_W-1:0]  wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_d;
  logic [FILL_W-1:0] fill_d;
  logic [FILL_W-1:0] pop_n;
  logic              pop_ok;
  logic              ptr_en;

  assign full  = fill == FILL_W'(DEPTH);
  assign empty = fill == '0;

  // whole word normally; a short tail only once fetching is finished
  always_comb begin
    if (fill >= FILL_W'(LANES)) begin
      pop_ok = pop_req;
      pop_n  = pop_ok ? FILL_W'(LANES) : '0;
    end else begin
      pop_ok = pop_req && tail_ok && !empty;
      pop_n  = pop_ok ? fill : '0;
    end
  end

  always_comb begin
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      fill_d   = '0;
    end else begin
      wr_ptr_d = wr_ptr + PTR_W'(push);
      rd_ptr_d = rd_ptr + PTR_W'(pop_n);
      fill_d   = fill + FILL_W'(push) - pop_n;
    end
  end

  assign ptr_en = flush || push || pop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else if (ptr_en) begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      fill   <= fill_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) begin
      mem[wr_ptr] <= push_data;
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign word[j*BYTE_W +: BYTE_W] =
      (FILL_W'(j) < fill) ? mem[rd_ptr + PTR_W'(j)] : '0;
  end

endmodule

// File: rtl/nand_pf_engine.sv
module nand_pf_engine
  import nand_pf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = 14,
  parameter int CS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              word_pop,
  output logic [REG_W-1:0]  word_data,
  output logic              thr_hit,
  output logic [CS_W-1:0]   nand_cs,
  output logic              nand_re,
  input  logic              nand_ready,
  input  logic [BYTE_W-1:0] nand_dq
);

  localparam int FILL_W  = $clog2(DEPTH + 1);
  localparam int THR_MAX = DEPTH;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [CS_W-1:0]   cfg_cs;
  logic [THR_W-1:0]  cfg_thr;
  logic [CNT_W-1:0]  cfg_cnt;
  logic              start_req;
  logic              stop_req;
  logic              busy;
  logic [CNT_W-1:0]  remaining;
  logic [FILL_W-1:0] fill;
  logic              fifo_full;
  logic              fifo_empty;
  logic              tail_ok;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  nand_pf_regs #(
    .CNT_W  (CNT_W),
    .CS_W   (CS_W),
    .FILL_W (FILL_W),
    .THR_MAX(THR_MAX)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .busy     (busy),
    .remaining(remaining),
    .fill     (fill),
    .cfg_cs   (cfg_cs),
    .cfg_thr  (cfg_thr),
    .cfg_cnt  (cfg_cnt),
    .start_req(start_req),
    .stop_req (stop_req),
    .reg_rdata(reg_rdata)
  );

  nand_pf_fetch #(
    .CNT_W(CNT_W)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_req (start_req),
    .stop_req  (stop_req),
    .cfg_cnt   (cfg_cnt),
    .fifo_full (fifo_full),
    .fifo_empty(fifo_empty),
    .nand_ready(nand_ready),
    .busy      (busy),
    .remaining (remaining),
    .nand_re   (nand_re)
  );

  assign tail_ok = remaining == '0;

  nand_pf_fifo #(
    .DEPTH (DEPTH),
    .FILL_W(FILL_W),
    .BYTE_W(BYTE_W),
    .LANES (LANES)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .flush    (stop_req || start_req),
    .push     (nand_re),
    .push_data(nand_dq),
    .pop_req  (word_pop),
    .tail_ok  (tail_ok),
    .word     (word_data),
    .fill     (fill),
    .full     (fifo_full),
    .empty    (fifo_empty)
  );

  assign nand_cs = cfg_cs;
  assign thr_hit = busy && !fifo_empty &&
                   ((fill >= FILL_W'(cfg_thr)) || tail_ok);

endmodule

// File: rtl/nand_pf_checker.sv
module nand_pf_checker #(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 14,
  parameter int FILL_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              word_pop,
  input logic              nand_re,
  input logic              nand_ready,
  input logic              busy,
  input logic [CNT_W-1:0]  remaining,
  input logic [FILL_W-1:0] fill
);

  logic stop_wr;
  logic run_wr;
  assign stop_wr = reg_wr && (reg_addr == 2'd2) && !reg_wdata[0];
  assign run_wr  = reg_wr && (reg_addr == 2'd2) && reg_wdata[0];

  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FILL_W'(DEPTH));

  assert_strobe_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nand_re |-> (busy && nand_ready && (remaining != '0) && (fill != FILL_W'(DEPTH))));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_re && !stop_wr) |=> (remaining == $past(remaining) - CNT_W'(1)));

  assert_busy_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(run_wr));

  assert_auto_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (remaining == '0) && (fill == '0)) |=> !busy);

  assert_stop_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> (!busy && (remaining == '0) && (fill == '0)));

  assert_short_pop_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_pop && (fill < FILL_W'(4)) && (remaining != '0) && !nand_re && !stop_wr)
      |=> (fill == $past(fill)));

endmodule

bind nand_pf_engine nand_pf_checker #(
  .DEPTH (DEPTH),
  .CNT_W (CNT_W),
  .FILL_W(FILL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .word_pop  (word_pop),
  .nand_re   (nand_re),
  .nand_ready(nand_ready),
  .busy      (busy),
  .remaining (remaining),
  .fill      (fill)
);

// File: tb/tb_nand_pf_engine.sv
`timescale 1ns/1ps
module tb_nand_pf_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        word_pop;
  logic [31:0] word_data;
  logic        thr_hit;
  logic [7:0]  nand_cs;
  logic        nand_re;
  logic        nand_ready;
  logic [7:0]  nand_dq;

  logic        rdy_rand;
  logic        rdy_force;
  logic        rnd_bit;
  logic [31:0] kcnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  nand_pf_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .word_pop(word_pop),
    .word_data(word_data), .thr_hit(thr_hit), .nand_cs(nand_cs),
    .nand_re(nand_re), .nand_ready(nand_ready), .nand_dq(nand_dq)
  );

  function automatic logic [7:0] pat(input logic [31:0] k);
    logic [31:0] t;
    t = (k * 32'd29) ^ (k >> 7) ^ 32'hA5;
    return t[7:0];
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] base, input int idx, input int n);
    logic [31:0] w;
    w = '0;
    for (int j = 0; j < 4; j++)
      if (idx + j < n) w[j*8 +: 8] = pat(base + 32'(idx + j));
    return w;
  endfunction

  function automatic logic [31:0] cfg1(input logic [7:0] cs, input logic [6:0] thr,
                                       input logic en, input logic dir);
    return {cs, 9'b0, thr, en, 6'b0, dir};
  endfunction

  // NAND model: byte value depends on the strobe index
  always @(posedge clk) begin
    if (!rst_n) kcnt <= '0;
    else if (nand_re) kcnt <= kcnt + 1;
  end
  assign nand_dq = pat(kcnt);

  always @(negedge clk) rnd_bit <= ($urandom % 4) != 0;
  assign nand_ready = rdy_rand ? rnd_bit : rdy_force;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic pop(output logic [31:0] w);
    @(negedge clk);
    word_pop = 1'b1;
    #0.5;
    w = word_data;
    @(negedge clk);
    word_pop = 1'b0;
  endtask

  task automatic ready_for(input int c);
    @(negedge clk);
    rdy_force = 1'b1;
    repeat (c) @(negedge clk);
    rdy_force = 1'b0;
  endtask

  task automatic start_xfer(input logic [31:0] c1, input int n, output logic [31:0] base);
    wr(2'd0, c1);
    wr(2'd1, 32'(n));
    base = kcnt;
    wr(2'd2, 32'd1);
  endtask

  // host drain loop: fill/4 words per status read, short tail when fetching is over
  task automatic drain(input logic [31:0] base, input int n);
    int idx;
    logic [31:0] s, w;
    idx = 0;
    while (idx < n) begin
      int fl, rm, nw;
      rd(2'd3, s);
      fl = int'(s[30:24]);
      rm = int'(s[13:0]);
      nw = fl / 4;
      if (rm == 0 && (fl % 4) != 0) nw++;
      for (int i = 0; i < nw; i++) begin
        pop(w);
        check("R5 R7 word data", w, exp_word(base, idx, n));
        idx += 4;
      end
      repeat ($urandom % 3) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    rd(2'd2, s);
    check("R9 busy cleared after drain", s, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w, base;
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    word_pop = 1'b0; rdy_rand = 1'b0; rdy_force = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check("R1 register reset value", v, 32'd0);
    end
    check("R1 nand_re low", 32'(nand_re), 32'd0);
    check("R1 thr_hit low", 32'(thr_hit), 32'd0);

    // R2 legal threshold, illegal threshold
    wr(2'd0, 32'h3C00_4080 | 32'h0000_007E);
    rd(2'd0, v);
    check("R2 config1 readback", v, 32'h3C00_4080);
    check("R2 nand_cs", 32'(nand_cs), 32'h3C);
    wr(2'd0, 32'h5A00_4180);
    rd(2'd0, v);
    check("R2 threshold above 64 ignored", v, 32'h3C00_4080);

    // R4 refused starts
    wr(2'd0, 32'h0100_1000); wr(2'd1, 32'd10); wr(2'd2, 32'd1);
    rd(2'd2, v); check("R4 no start when disabled", v, 32'd0);
    wr(2'd0, 32'h0100_1081); wr(2'd2, 32'd1);
    rd(2'd2, v); check("R4 no start in write direction", v, 32'd0);
    wr(2'd0, 32'h0100_1080); wr(2'd1, 32'd0); wr(2'd2, 32'd1);
    rd(2'd2, v); check("R4 no start with zero count", v, 32'd0);

    // threshold, busy lockout, short pop, stop
    start_xfer(32'h0200_0880, 20, base);
    rd(2'd2, v); check("R4 busy after start", v, 32'd1);
    rd(2'd3, v); check("R8 status after start", v, 32'd20);
    wr(2'd1, 32'd99);
    rd(2'd1, v); check("R3 config2 locked", v, 32'd20);
    wr(2'd0, 32'h7F00_0080);
    rd(2'd0, v); check("R3 config1 locked", v, 32'h0200_0880);
    ready_for(2);
    rd(2'd3, v); check("R5 R8 two strobes", v, (32'd2 << 24) | 32'd18);
    check("R11 below threshold", 32'(thr_hit), 32'd0);
    pop(w);
    rd(2'd3, v); check("R7 short pop ignored while fetching", v, (32'd2 << 24) | 32'd18);
    ready_for(3);
    check("R11 fill 5 of 8", 32'(thr_hit), 32'd0);
    ready_for(3);
    #0.5;
    check("R11 fill reaches threshold", 32'(thr_hit), 32'd1);
    wr(2'd2, 32'd0);
    rd(2'd3, v); check("R10 status cleared by stop", v, 32'd0);
    rd(2'd2, v); check("R10 busy cleared by stop", v, 32'd0);
    check("R10 thr_hit after stop", 32'(thr_hit), 32'd0);

    // R6 stall when full
    rdy_force = 1'b1;
    start_xfer(32'h0500_4080, 100, base);
    repeat (100) @(negedge clk);
    rd(2'd3, v); check("R6 full FIFO stalls", v, (32'd64 << 24) | 32'd36);
    check("R6 no strobe while full", 32'(nand_re), 32'd0);
    check("R11 full FIFO", 32'(thr_hit), 32'd1);
    drain(base, 100);

    // R7 partial tail
    start_xfer(32'h0000_0480, 6, base);
    repeat (10) @(negedge clk);
    rd(2'd3, v); check("R8 all six fetched", v, 32'd6 << 24);
    pop(w); check("R7 first word", w, exp_word(base, 0, 6));
    rd(2'd3, v); check("R7 two bytes left", v, 32'd2 << 24);
    pop(w); check("R7 zero padded tail", w, exp_word(base, 4, 6));
    repeat (2) @(negedge clk);
    rd(2'd2, v); check("R9 busy cleared after tail", v, 32'd0);

    // random transfers
    rdy_force = 1'b0;
    rdy_rand  = 1'b1;
    for (int t = 0; t < 12; t++) begin
      int n;
      logic [6:0] thr;
      n   = 1 + int'($urandom % 300);
      thr = 7'($urandom % 65);
      start_xfer(cfg1(8'($urandom), thr, 1'b1, 1'b0), n, base);
      drain(base, n);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule